// File: doc/BRIEF.md
# Multiply-Step Shift-Add Unit

This block provides one step of a shift-and-add multiply, together with a small sequencer that repeats that step to form a full product. In each step the low word of the first source is shifted right by one place, and the true sign of the previous sum (N xor V) is fed back into the top bit. The second operand is then added if bit 0 of the multiplier register Y is set. Y shifts right at the same time and takes the source bit that fell off. The step also returns new integer flags for the 32-bit and the 64-bit views of the addition.

The single-step port takes all of its state as inputs (source, operand, Y, N, V). It returns registered results one cycle later, so software-style sequences can be built around it. The sequencer port takes a multiplicand and a multiplier. It clears the accumulator and the flags, loads Y with the multiplier and runs DW steps. It then runs one more step with a forced zero addend, which produces the signed-multiplicand high word. Because the unsigned product is wanted, the sequencer adds the multiplier to the high word when the multiplicand's top bit is set.

Top module: `mstep_unit`

## Requirements
- R1: The partial value is the low DW bits of the first source shifted right by one, with (N xor V) placed in bit DW-1.
- R2: The addend equals the second operand when Y bit 0 is 1 and is zero when Y bit 0 is 0.
- R3: The step result is the partial value plus the addend, modulo 2^DW, in the low DW bits of the result output; the upper DW bits are zero.
- R4: The next Y is the input Y shifted right by one, with bit 0 of the first source (before shifting) in bit DW-1.
- R5: The narrow flags are {N,Z,V,C} at bits 3..0: N is result bit DW-1, Z is set for a zero result, V is set when partial and addend agree in sign and the result sign differs, and C is the carry out of bit DW-1.
- R6: The wide flags use the same {N,Z,V,C} order for the zero-extended 2*DW-bit addition: N=0, V=0, C=0 and Z set when the result is zero.
- R7: A single-step request raises the step valid output for exactly the next cycle; the step outputs change only in that cycle.
- R8: After reset every output is zero and the sequencer is idle.
- R9: A multiply request accepted while idle raises busy on the next cycle; busy stays high and the product valid output pulses for one cycle exactly DW+1 cycles after the request edge, when busy falls.
- R10: The sequenced product equals the unsigned DW x DW product of the multiplicand and multiplier, and is held until the next product.
- R11: A multiply request while busy is ignored: the running product and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stp_go | input | 1 | Single-step request |
| stp_src1 | input | DW | First source (accumulator) |
| stp_src2 | input | DW | Second operand (multiplicand) |
| stp_y | input | DW | Multiplier register value |
| stp_n | input | 1 | Current N flag |
| stp_v | input | 1 | Current V flag |
| stp_valid | output | 1 | Step result valid (one cycle) |
| stp_rd | output | 2*DW | Step result, upper half zero |
| stp_y_nx | output | DW | Next Y value |
| stp_icc | output | 4 | Narrow flags {N,Z,V,C} |
| stp_xcc | output | 4 | Wide flags {N,Z,V,C} |
| mul_go | input | 1 | Start a sequenced multiply |
| mul_a | input | DW | Multiplicand |
| mul_b | input | DW | Multiplier |
| mul_busy | output | 1 | Sequencer running |
| mul_valid | output | 1 | Product valid (one cycle) |
| mul_prod | output | 2*DW | Unsigned product, held |

## Verification
Single-step results are due one clock edge after the edge that samples the request. The bench raises the request on a falling edge and reads every step output at the next falling edge. It then reads again one cycle later to see the valid pulse end with the outputs unchanged. The product is due DW+1 edges after the request edge. The bench counts falling edges from the request until the valid output rises and compares that count with DW+2. A second request injected mid-run must leave both the count and the product untouched.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccode_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } sq_state_t;

endpackage

// File: rtl/mstep_core.sv
module mstep_core
    import mstep_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   src1,
    input  logic [DW-1:0]   src2,
    input  logic [DW-1:0]   y_cur,
    input  logic            n_cur,
    input  logic            v_cur,
    input  logic            add_en,
    output logic [DW-1:0]   res,
    output logic [DW-1:0]   y_nx,
    output ccode_t          icc
);

    logic [DW-1:0] part;
    logic [DW-1:0] addend;
    logic [DW:0]   sum;

    always_comb begin
        part   = {n_cur ^ v_cur, src1[DW-1:1]};
        addend = (y_cur[0] && add_en) ? src2 : '0;
        sum    = {1'b0, part} + {1'b0, addend};
        res    = sum[DW-1:0];
        y_nx   = {src1[0], y_cur[DW-1:1]};
        icc.n  = sum[DW-1];
        icc.z  = (sum[DW-1:0] == '0);
        icc.v  = (part[DW-1] == addend[DW-1]) && (sum[DW-1] != part[DW-1]);
        icc.c  = sum[DW];
    end

endmodule

// File: rtl/mstep_seq.sv
module mstep_seq
    import mstep_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [DW-1:0]   mcand_in,
    input  logic [DW-1:0]   mplier_in,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] prod
);

    localparam int CNT_W = $clog2(DW);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DW - 1);

    typedef struct packed {
        sq_state_t         st;
        logic [CNT_W-1:0]  cnt;
        logic [DW-1:0]     acc;
        logic [DW-1:0]     yreg;
        logic              n;
        logic              v;
        logic [DW-1:0]     mcand;
        logic [DW-1:0]     mplier;
        logic              done;
        logic [2*DW-1:0]   prod;
    } seq_t;

    seq_t sq_d, sq_q;

    logic [DW-1:0] core_res;
    logic [DW-1:0] core_y;
    ccode_t        core_icc;
    logic          seq_unused;

    mstep_core #(.DW(DW)) u_core (
        .src1   (sq_q.acc),
        .src2   (sq_q.mcand),
        .y_cur  (sq_q.yreg),
        .n_cur  (sq_q.n),
        .v_cur  (sq_q.v),
        .add_en (sq_q.st == SQ_RUN),
        .res    (core_res),
        .y_nx   (core_y),
        .icc    (core_icc)
    );

    assign seq_unused = core_icc.z ^ core_icc.c;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        case (sq_q.st)
            SQ_IDLE: begin
                if (go) begin
                    sq_d.st     = SQ_RUN;
                    sq_d.cnt    = '0;
                    sq_d.acc    = '0;
                    sq_d.yreg   = mplier_in;
                    sq_d.n      = 1'b0;
                    sq_d.v      = 1'b0;
                    sq_d.mcand  = mcand_in;
                    sq_d.mplier = mplier_in;
                end
            end
            SQ_RUN: begin
                sq_d.acc  = core_res;
                sq_d.yreg = core_y;
                sq_d.n    = core_icc.n;
                sq_d.v    = core_icc.v;
                sq_d.cnt  = sq_q.cnt + CNT_W'(1);
                if (sq_q.cnt == LAST_STEP) begin
                    sq_d.st = SQ_FIN;
                end
            end
            SQ_FIN: begin
                sq_d.prod = {core_res + (sq_q.mcand[DW-1] ? sq_q.mplier : '0), core_y};
                sq_d.done = 1'b1;
                sq_d.st   = SQ_IDLE;
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy = (sq_q.st != SQ_IDLE);
    assign done = sq_q.done;
    assign prod = sq_q.prod;

endmodule

// File: rtl/mstep_unit.sv
module mstep_unit
    import mstep_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stp_go,
    input  logic [DW-1:0]   stp_src1,
    input  logic [DW-1:0]   stp_src2,
    input  logic [DW-1:0]   stp_y,
    input  logic            stp_n,
    input  logic            stp_v,
    output logic            stp_valid,
    output logic [2*DW-1:0] stp_rd,
    output logic [DW-1:0]   stp_y_nx,
    output logic [3:0]      stp_icc,
    output logic [3:0]      stp_xcc,
    input  logic            mul_go,
    input  logic [DW-1:0]   mul_a,
    input  logic [DW-1:0]   mul_b,
    output logic            mul_busy,
    output logic            mul_valid,
    output logic [2*DW-1:0] mul_prod
);

    typedef struct packed {
        logic            valid;
        logic [DW-1:0]   res;
        logic [DW-1:0]   y;
        ccode_t          icc;
        ccode_t          xcc;
    } step_t;

    step_t st_d, st_q;

    logic [DW-1:0] c_res;
    logic [DW-1:0] c_y;
    ccode_t        c_icc;

    mstep_core #(.DW(DW)) u_core (
        .src1   (stp_src1),
        .src2   (stp_src2),
        .y_cur  (stp_y),
        .n_cur  (stp_n),
        .v_cur  (stp_v),
        .add_en (1'b1),
        .res    (c_res),
        .y_nx   (c_y),
        .icc    (c_icc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = stp_go;
        if (stp_go) begin
            st_d.res   = c_res;
            st_d.y     = c_y;
            st_d.icc   = c_icc;
            st_d.xcc.n = 1'b0;
            st_d.xcc.z = c_icc.z;
            st_d.xcc.v = 1'b0;
            st_d.xcc.c = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stp_valid = st_q.valid;
    assign stp_rd    = {{DW{1'b0}}, st_q.res};
    assign stp_y_nx  = st_q.y;
    assign stp_icc   = st_q.icc;
    assign stp_xcc   = st_q.xcc;

    mstep_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (mul_go),
        .mcand_in  (mul_a),
        .mplier_in (mul_b),
        .busy      (mul_busy),
        .done      (mul_valid),
        .prod      (mul_prod)
    );

endmodule

// File: rtl/mstep_chk.sv
module mstep_chk #(
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stp_go,
    input logic            stp_valid,
    input logic [2*DW-1:0] stp_rd,
    input logic [3:0]      stp_icc,
    input logic [3:0]      stp_xcc,
    input logic            mul_go,
    input logic            mul_busy,
    input logic            mul_valid,
    input logic [2*DW-1:0] mul_prod
);

    // R7
    step_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stp_go |=> stp_valid);

    // R7
    step_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stp_go |=> (!stp_valid && $stable(stp_rd)));

    // R6
    wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stp_valid |-> (stp_xcc[2] == (stp_rd == '0)));

    // R5
    narrow_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stp_valid |-> (stp_icc[3] == stp_rd[DW-1]));

    // R9
    mul_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go && !mul_busy) |=> mul_busy);

    // R9
    mul_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_valid |-> (!mul_busy && $past(mul_busy)));

    // R10
    mul_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mul_valid |-> $stable(mul_prod));

endmodule

bind mstep_unit mstep_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stp_go    (stp_go),
    .stp_valid (stp_valid),
    .stp_rd    (stp_rd),
    .stp_icc   (stp_icc),
    .stp_xcc   (stp_xcc),
    .mul_go    (mul_go),
    .mul_busy  (mul_busy),
    .mul_valid (mul_valid),
    .mul_prod  (mul_prod)
);

// File: tb/mstep_unit_bench.sv
`timescale 1ns/1ps
module mstep_unit_bench;

    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stp_go = 1'b0;
    logic [DW-1:0]   stp_src1 = '0;
    logic [DW-1:0]   stp_src2 = '0;
    logic [DW-1:0]   stp_y = '0;
    logic            stp_n = 1'b0;
    logic            stp_v = 1'b0;
    logic            stp_valid;
    logic [2*DW-1:0] stp_rd;
    logic [DW-1:0]   stp_y_nx;
    logic [3:0]      stp_icc;
    logic [3:0]      stp_xcc;
    logic            mul_go = 1'b0;
    logic [DW-1:0]   mul_a = '0;
    logic [DW-1:0]   mul_b = '0;
    logic            mul_busy;
    logic            mul_valid;
    logic [2*DW-1:0] mul_prod;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mstep_unit #(.DW(DW)) u_mstep_unit (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_res(input logic [31:0] s1, s2, y, input logic n, v);
        logic [31:0] part, add;
        part = {n ^ v, s1[31:1]};
        add  = y[0] ? s2 : 32'd0;
        return part + add;
    endfunction

    function automatic logic [3:0] ref_icc(input logic [31:0] s1, s2, y, input logic n, v);
        logic [31:0] part, add;
        logic [32:0] sum;
        part = {n ^ v, s1[31:1]};
        add  = y[0] ? s2 : 32'd0;
        sum  = {1'b0, part} + {1'b0, add};
        return {sum[31], sum[31:0] == 32'd0,
                (part[31] == add[31]) && (sum[31] != part[31]), sum[32]};
    endfunction

    task automatic run_step(input logic [31:0] s1, s2, y, input logic n, v, input string tag);
        logic [31:0] er;
        logic [63:0] held;
        er = ref_res(s1, s2, y, n, v);
        @(negedge clk);
        stp_src1 = s1; stp_src2 = s2; stp_y = y; stp_n = n; stp_v = v; stp_go = 1'b1;
        @(negedge clk);
        stp_go = 1'b0;
        check(stp_valid == 1'b1, "R7 valid", {63'd0, stp_valid}, 64'd1);
        check(stp_rd == {32'd0, er}, tag, stp_rd, {32'd0, er});
        check(stp_y_nx == {s1[0], y[31:1]}, "R4 y", {32'd0, stp_y_nx}, {32'd0, s1[0], y[31:1]});
        check(stp_icc == ref_icc(s1, s2, y, n, v), "R5 icc", {60'd0, stp_icc},
              {60'd0, ref_icc(s1, s2, y, n, v)});
        check(stp_xcc == {1'b0, er == 32'd0, 2'b00}, "R6 xcc", {60'd0, stp_xcc},
              {60'd0, 1'b0, er == 32'd0, 2'b00});
        held = stp_rd;
        stp_src1 = ~s1;
        @(negedge clk);
        check(!stp_valid && stp_rd == held, "R7 hold", stp_rd, held);
    endtask

    task automatic run_mul(input logic [31:0] a, b, input bit inject);
        int waited;
        logic [63:0] exp;
        exp = {32'd0, a} * {32'd0, b};
        @(negedge clk);
        mul_a = a; mul_b = b; mul_go = 1'b1;
        @(negedge clk);
        mul_go = 1'b0;
        waited = 1;
        check(mul_busy == 1'b1, "R9 busy", {63'd0, mul_busy}, 64'd1);
        while (!mul_valid && waited < 100) begin
            @(negedge clk);
            waited++;
            if (inject && waited == 5) begin
                mul_a = ~a; mul_b = b ^ 32'h5a5a_0f0f; mul_go = 1'b1;
            end else begin
                mul_go = 1'b0;
            end
        end
        check(waited == DW + 2, inject ? "R11 timing" : "R9 latency", waited, DW + 2);
        check(mul_prod == exp, inject ? "R11 product" : "R10 product", mul_prod, exp);
        check(!mul_busy, "R9 idle", {63'd0, mul_busy}, 64'd0);
        @(negedge clk);
        check(!mul_valid && mul_prod == exp, "R10 hold", mul_prod, exp);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(stp_valid == 0 && stp_rd == 0 && stp_y_nx == 0 && stp_icc == 0 && stp_xcc == 0
              && mul_busy == 0 && mul_valid == 0 && mul_prod == 0, "R8 reset", stp_rd, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mul_busy == 0 && stp_valid == 0, "R8 idle", {62'd0, mul_busy, stp_valid}, 64'd0);

        run_step(32'h0000_0002, 32'd5, 32'h1, 1'b0, 1'b0, "R2 add taken");
        run_step(32'h0000_0002, 32'd5, 32'h2, 1'b0, 1'b0, "R2 add skipped");
        run_step(32'h0000_0001, 32'd9, 32'h0, 1'b1, 1'b0, "R1 sign in");
        run_step(32'h0000_0001, 32'd9, 32'h0, 1'b1, 1'b1, "R1 sign cancel");
        run_step(32'hffff_fffe, 32'd1, 32'h1, 1'b0, 1'b0, "R3 overflow");
        run_step(32'hffff_fffe, 32'd1, 32'h1, 1'b1, 1'b0, "R3 carry zero");
        run_step(32'h8000_0000, 32'h8000_0000, 32'hffff_ffff, 1'b0, 1'b1, "R3 neg sum");
        for (int i = 0; i < 40; i++) begin
            run_step($urandom, $urandom, $urandom, 1'($urandom), 1'($urandom), "R3 random");
        end

        run_mul(32'd0, 32'h1234_5678, 1'b0);
        run_mul(32'd1, 32'd1, 1'b0);
        run_mul(32'hffff_ffff, 32'hffff_ffff, 1'b0);
        run_mul(32'h8000_0000, 32'd3, 1'b0);
        run_mul(32'd7, 32'h8000_0001, 1'b0);
        for (int i = 0; i < 15; i++) begin
            run_mul($urandom, $urandom, 1'b0);
        end
        run_mul(32'hdead_beef, 32'h0bad_f00d, 1'b1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule